// File: doc/BRIEF.md
# Buffered NOR Program Sequencer

This block sits on the host side of a parallel NOR flash and writes a short run of words (one to 32) into the array with the flash's write-buffer programming protocol. A local requester gives a start address, a word count and a mode bit in one cycle. The block then fetches each data word by index from a source the requester holds. It produces the flash write and read cycles, checks the status word the flash returns, and ends with a one-cycle done pulse that carries an outcome code.

The bus is modelled as single-cycle write and read strobes. Every strobe is followed by a fixed number of quiet cycles before the next bus action. Read data is sampled at the end of that quiet time. The buffered flow works as follows. It asks for the write buffer and repeats the request until the flash reports the buffer free. It sends the count minus one and streams the data words to consecutive addresses. It then confirms and waits for the flash to report ready. Last, it reads the failure and lock bits from the status word, clears the status and, after a clean result, returns the flash to array reads. A single-word mode sends a one-word program command in place of the buffer handshake. A poll limit keeps a flash that never reports ready from stalling the block.

Top module: `bufprog_seq`

## Requirements
- R1: In buffered mode the block writes command 0xE8 at the start address, then reads status. While status bit 7 reads 0 it repeats the write and the read. When bit 7 reads 1 it goes on.
- R2: After the buffer is granted, the block writes the value N-1 at the start address, where N is the requested word count.
- R3: Data word i (i = 0..N-1) is taken from source index i and written at start address + i, in increasing i. No data write falls outside start .. start+N-1.
- R4: After the last data word the block writes 0xD0 at the start address. It then reads status repeatedly until bit 7 reads 1.
- R5: When ready is seen, the outcome code is 2 if status bit 1 is set, otherwise 1 if bit 4 is set, otherwise 0. Command 0x50 is then written at the start address.
- R6: Only after outcome 0 does the block write 0xFF at the start address, after the 0x50 write and before done.
- R7: A buffered request with a count of 0 or more than 32 ends with outcome 3. It makes no bus cycle, and done is raised in the cycle after the request is taken.
- R8: The slow-alignment flag is 1 at done for a buffered request whose start address has nonzero low five bits. It is 0 for an aligned buffered request and for any single-word request.
- R9: In single-word mode the block writes 0x40 at the start address, then source word 0 at the start address. It then polls, decodes and finishes as in R4 to R6. The count input is ignored.
- R10: Outcome 4 is reported when MAX_POLLS status reads in a row, within one polling phase, return bit 7 = 0. No bus cycle follows the last of those reads. MAX_POLLS-1 not-ready reads followed by a ready read do not time out.
- R11: Write and read strobes never overlap. Two strobes are at least WAIT+1 cycles apart. Done lasts exactly one cycle.
- R12: After reset the block is idle, with busy, done and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request; taken when busy is low |
| req_single | input | 1 | 1 selects single-word programming |
| req_addr | input | AW | Start address of the run |
| req_count | input | CNTW | Number of words N |
| src_idx | output | CNTW | Index of the data word wanted from the source |
| src_data | input | DW | Data word at src_idx |
| fl_addr | output | AW | Flash address for the current strobe |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | One-cycle flash write strobe |
| fl_re | output | 1 | One-cycle flash read strobe |
| fl_rdata | input | DW | Status word from the flash, valid at the end of the wait time |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Outcome: 0 ok, 1 program fail, 2 locked, 3 bad size, 4 timeout |
| warn_slow | output | 1 | Buffered start not aligned to 32 words |

## Verification
The hardest cases to reach are the poll-limit boundaries. These are a run of exactly MAX_POLLS-1 not-ready reads that must still succeed, and a run of MAX_POLLS that must abort in the grant phase and in the completion phase. The bench plays the flash with a scripted list of status replies. It builds that list per run from the wanted number of not-ready replies, so each boundary is hit on purpose. The bench also sweeps every word count from 1 to 32 on aligned and unaligned starts, with changing retry counts and final status words.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP_W, S_SETUP_R, S_SETUP_E, S_CNT_W, S_DATA_W, S_CONF_W,
    S_PROG_W, S_PDAT_W, S_POLL_R, S_POLL_E, S_CLR_W, S_ARR_W, S_DONE
  } bps_state_t;

  localparam logic [2:0] OUT_OK   = 3'd0;
  localparam logic [2:0] OUT_FAIL = 3'd1;
  localparam logic [2:0] OUT_LOCK = 3'd2;
  localparam logic [2:0] OUT_SIZE = 3'd3;
  localparam logic [2:0] OUT_TIME = 3'd4;

  localparam logic [7:0] OP_BUF_SETUP = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_WORD_PROG = 8'h40;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_READ_ARR  = 8'hFF;

  localparam int SB_READY = 7;
  localparam int SB_FAIL  = 4;
  localparam int SB_LOCK  = 1;

  // lock outranks program failure: a locked block raises both bits
  function automatic logic [2:0] status_outcome(input logic [7:0] sr);
    if (sr[SB_LOCK])      return OUT_LOCK;
    else if (sr[SB_FAIL]) return OUT_FAIL;
    else                  return OUT_OK;
  endfunction

  function automatic logic count_bad(input int unsigned n, input int unsigned lim);
    return (n == 0) || (n > lim);
  endfunction
endpackage

// File: rtl/bps_pacer.sv
module bps_pacer #(
  parameter int WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  localparam int GW = $clog2(WAIT + 2);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '0;
    else if (fire)       gap <= GW'(WAIT);
    else if (gap != '0)  gap <= gap - 1'b1;
  end

  assign ready = (gap == '0);
endmodule

// File: rtl/bps_poll_guard.sv
module bps_poll_guard #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic expire
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  logic [PW-1:0] misses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     misses <= '0;
    else if (clear) misses <= '0;
    else if (miss)  misses <= misses + 1'b1;
  end

  assign expire = miss && (misses == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/bps_status_decode.sv
module bps_status_decode
  import bps_pkg::*;
(
  input  logic [7:0] sr,
  output logic       sr_ready,
  output logic [2:0] sr_code
);
  assign sr_ready = sr[SB_READY];
  assign sr_code  = status_outcome(sr);
endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
  import bps_pkg::*;
#(
  parameter int AW        = 22,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  parameter int WAIT      = 2,
  parameter int MAX_POLLS = 1024,
  parameter int CNTW      = $clog2(MAX_WORDS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_single,
  input  logic [AW-1:0]   req_addr,
  input  logic [CNTW-1:0] req_count,
  output logic [CNTW-1:0] src_idx,
  input  logic [DW-1:0]   src_data,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   fl_wdata,
  output logic            fl_we,
  output logic            fl_re,
  input  logic [DW-1:0]   fl_rdata,
  output logic            busy,
  output logic            done,
  output logic [2:0]      err_code,
  output logic            warn_slow
);
  localparam int ALB = $clog2(MAX_WORDS);

  bps_state_t      state;
  logic [AW-1:0]   start_q;
  logic [CNTW-1:0] count_q;
  logic [CNTW-1:0] idx_q;
  logic [2:0]      code_q;
  logic            warn_q;
  logic            data_q;

  // named internal events
  logic            acc, oversize, pace_ok, eval, miss, expire, guard_clr;
  logic            iss_we, iss_re;
  logic [AW-1:0]   iss_addr;
  logic [DW-1:0]   iss_data;
  logic            sr_ready;
  logic [2:0]      sr_code;
  logic            unused_hi;

  assign unused_hi = ^fl_rdata[DW-1:8];
  assign acc       = (state == S_IDLE) && req_valid;
  assign oversize  = !req_single && count_bad(int'(req_count), MAX_WORDS);
  assign eval      = pace_ok && ((state == S_SETUP_E) || (state == S_POLL_E));
  assign miss      = eval && !sr_ready;
  assign guard_clr = acc || (iss_we && ((state == S_CONF_W) || (state == S_PDAT_W)));

  bps_pacer #(.WAIT(WAIT)) u_pacer (
    .clk(clk), .rst_n(rst_n), .fire(iss_we || iss_re), .ready(pace_ok)
  );

  bps_poll_guard #(.MAX_POLLS(MAX_POLLS)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(guard_clr), .miss(miss), .expire(expire)
  );

  bps_status_decode u_dec (
    .sr(fl_rdata[7:0]), .sr_ready(sr_ready), .sr_code(sr_code)
  );

  always_comb begin
    iss_we   = 1'b0;
    iss_re   = 1'b0;
    iss_addr = start_q;
    iss_data = '0;
    if (pace_ok) begin
      case (state)
        S_SETUP_W: begin iss_we = 1'b1; iss_data = DW'(OP_BUF_SETUP); end
        S_SETUP_R, S_POLL_R: iss_re = 1'b1;
        S_CNT_W:   begin iss_we = 1'b1; iss_data = DW'(count_q - 1'b1); end
        S_DATA_W:  begin
          iss_we   = 1'b1;
          iss_addr = start_q + AW'(idx_q);
          iss_data = src_data;
        end
        S_CONF_W:  begin iss_we = 1'b1; iss_data = DW'(OP_CONFIRM); end
        S_PROG_W:  begin iss_we = 1'b1; iss_data = DW'(OP_WORD_PROG); end
        S_PDAT_W:  begin iss_we = 1'b1; iss_data = src_data; end
        S_CLR_W:   begin iss_we = 1'b1; iss_data = DW'(OP_CLR_STAT); end
        S_ARR_W:   begin iss_we = 1'b1; iss_data = DW'(OP_READ_ARR); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      start_q  <= '0;
      count_q  <= '0;
      idx_q    <= '0;
      code_q   <= OUT_OK;
      warn_q   <= 1'b0;
      data_q   <= 1'b0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else begin
      fl_we  <= iss_we;
      fl_re  <= iss_re;
      data_q <= iss_we && (state == S_DATA_W);
      if (iss_we || iss_re) begin
        fl_addr  <= iss_addr;
        fl_wdata <= iss_data;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          start_q <= req_addr;
          count_q <= req_count;
          idx_q   <= '0;
          warn_q  <= !req_single && (req_addr[ALB-1:0] != '0);
          if (oversize) begin
            code_q <= OUT_SIZE;
            state  <= S_DONE;
          end else begin
            code_q <= OUT_OK;
            state  <= req_single ? S_PROG_W : S_SETUP_W;
          end
        end
        S_SETUP_W: if (iss_we) state <= S_SETUP_R;
        S_SETUP_R: if (iss_re) state <= S_SETUP_E;
        S_SETUP_E: if (eval) begin
          if (sr_ready) state <= S_CNT_W;
          else if (expire) begin code_q <= OUT_TIME; state <= S_DONE; end
          else state <= S_SETUP_W;
        end
        S_CNT_W:  if (iss_we) state <= S_DATA_W;
        S_DATA_W: if (iss_we) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == count_q - 1'b1) state <= S_CONF_W;
        end
        S_CONF_W: if (iss_we) state <= S_POLL_R;
        S_PROG_W: if (iss_we) state <= S_PDAT_W;
        S_PDAT_W: if (iss_we) state <= S_POLL_R;
        S_POLL_R: if (iss_re) state <= S_POLL_E;
        S_POLL_E: if (eval) begin
          if (sr_ready) begin code_q <= sr_code; state <= S_CLR_W; end
          else if (expire) begin code_q <= OUT_TIME; state <= S_DONE; end
          else state <= S_POLL_R;
        end
        S_CLR_W: if (iss_we) state <= (code_q == OUT_OK) ? S_ARR_W : S_DONE;
        S_ARR_W: if (iss_we) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign src_idx   = idx_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign err_code  = code_q;
  assign warn_slow = warn_q;
endmodule

// File: rtl/bufprog_seq_chk.sv
module bufprog_seq_chk #(
  parameter int AW   = 22,
  parameter int CNTW = 6,
  parameter int WAIT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fl_we,
  input logic            fl_re,
  input logic [AW-1:0]   fl_addr,
  input logic            busy,
  input logic            done,
  input logic [2:0]      err_code,
  input logic            acc,
  input logic            oversize,
  input logic            expire,
  input logic            data_q,
  input logic [AW-1:0]   start_q,
  input logic [CNTW-1:0] count_q
);
  logic [AW-1:0] offset;
  assign offset = fl_addr - start_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  generate if (WAIT > 0) begin : g_gap
    assert_strobe_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we || fl_re) |=> !(fl_we || fl_re));
  end endgenerate

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_data_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && data_q) |-> (offset < AW'(count_q)));

  assert_size_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && oversize) |=> (done && err_code == 3'd3 && !fl_we && !fl_re));

  assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (done && err_code == 3'd4));

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code <= 3'd4));

  assert_strobe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> busy);
endmodule

bind bufprog_seq bufprog_seq_chk #(.AW(AW), .CNTW(CNTW), .WAIT(WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
  .busy(busy), .done(done), .err_code(err_code), .acc(acc), .oversize(oversize),
  .expire(expire), .data_q(data_q), .start_q(start_q), .count_q(count_q)
);

// File: tb/bufprog_seq_bench.sv
module bufprog_seq_bench;
  localparam int AW = 16, DW = 16, MW = 32, WT = 2, MP = 6, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_single = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [CW-1:0] src_idx;
  logic [DW-1:0] src_data, fl_wdata, fl_rdata = '0;
  logic [AW-1:0] fl_addr;
  logic fl_we, fl_re, busy, done, warn_slow;
  logic [2:0] err_code;

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] cur_seed = 16'h0;

  logic [15:0] rsp [0:63];
  logic [15:0] wa [0:127], wd [0:127], ea [0:127], ed [0:127];
  int st [0:255];
  int wn = 0, rn = 0, sn = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pat(input logic [15:0] s, input int i);
    return (s + 16'(i) * 16'h0111) ^ 16'h5A00;
  endfunction

  assign src_data = pat(cur_seed, int'(src_idx));

  bufprog_seq #(.AW(AW), .DW(DW), .MAX_WORDS(MW), .WAIT(WT), .MAX_POLLS(MP)) u_bufprog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
    .req_addr(req_addr), .req_count(req_count), .src_idx(src_idx), .src_data(src_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .busy(busy), .done(done), .err_code(err_code), .warn_slow(warn_slow)
  );

  // flash model: log writes, answer reads from the script
  always @(negedge clk) begin
    if (fl_we) begin wa[wn] = fl_addr; wd[wn] = fl_wdata; wn++; st[sn] = cyc; sn++; end
    if (fl_re) begin fl_rdata = rsp[rn]; rn++; st[sn] = cyc; sn++; end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic single, input logic [15:0] a, input int n, input int sm,
                     input int pm, input logic [15:0] fin, input logic [15:0] seed);
    int ne = 0, nr = 0, ec = -1, lat = 0, bad = -1, gapbad = 0;
    logic ew;
    cur_seed = seed;
    if (!single && (n == 0 || n > MW)) ec = 3;
    else begin
      if (!single) begin
        for (int i = 0; i < sm && i < MP; i++) begin
          ea[ne] = a; ed[ne] = 16'hE8; ne++; rsp[nr] = 16'h0000; nr++;
        end
        if (sm >= MP) ec = 4;
        else begin
          ea[ne] = a; ed[ne] = 16'hE8; ne++; rsp[nr] = 16'h0080; nr++;
          ea[ne] = a; ed[ne] = 16'(n - 1); ne++;
          for (int i = 0; i < n; i++) begin ea[ne] = a + 16'(i); ed[ne] = pat(seed, i); ne++; end
          ea[ne] = a; ed[ne] = 16'hD0; ne++;
        end
      end else begin
        ea[ne] = a; ed[ne] = 16'h40; ne++;
        ea[ne] = a; ed[ne] = pat(seed, 0); ne++;
      end
      if (ec != 4) begin
        for (int i = 0; i < pm && i < MP; i++) begin rsp[nr] = 16'h0000; nr++; end
        if (pm >= MP) ec = 4;
        else begin
          rsp[nr] = fin; nr++;
          ec = fin[1] ? 2 : (fin[4] ? 1 : 0);
          ea[ne] = a; ed[ne] = 16'h50; ne++;
          if (ec == 0) begin ea[ne] = a; ed[ne] = 16'hFF; ne++; end
        end
      end
    end
    ew = !single && (a[4:0] != 5'd0);
    @(negedge clk);
    wn = 0; rn = 0; sn = 0;
    req_valid = 1'b1; req_single = single; req_addr = a; req_count = CW'(n);
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    check(done, "R4", "done seen", int'(done), 1);
    check(int'(err_code) == ec, "R5/R7/R10", "outcome code", int'(err_code), ec);
    check(warn_slow == ew, "R8", "slow flag", int'(warn_slow), int'(ew));
    if (ec == 3) check(lat == 1, "R7", "reject latency", lat, 1);
    @(negedge clk);
    check(!done, "R11", "done width", int'(done), 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < ne && i < wn; i++)
      if (bad < 0 && (wa[i] != ea[i] || wd[i] != ed[i])) bad = i;
    check(wn == ne, "R1/R2/R3/R4/R6/R9", "write count", wn, ne);
    if (bad >= 0)
      check(0, "R1/R2/R3/R4/R5/R6/R9", $sformatf("write %0d addr/data %h/%h vs %h/%h", bad,
            wa[bad], wd[bad], ea[bad], ed[bad]), int'(wd[bad]), int'(ed[bad]));
    else check(1, "R3", "write contents", 0, 0);
    check(rn == nr, "R1/R4/R10", "read count", rn, nr);
    for (int i = 1; i < sn; i++) if (st[i] - st[i-1] < WT + 1) gapbad++;
    check(gapbad == 0, "R11", "strobe spacing violations", gapbad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fl_we && !fl_re, "R12", "reset idle",
          int'({busy, done, fl_we, fl_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R12", "idle after release", int'({busy, done}), 0);
    // sweep every legal count, aligned and unaligned, various retries and results
    for (int n = 1; n <= MW; n++) begin
      logic [15:0] fin;
      fin = (n % 3 == 0) ? 16'h0080 : ((n % 3 == 1) ? 16'h0090 : 16'h0092);
      if (n % 4 == 0) fin = 16'h0080;
      run(1'b0, (n % 2 == 0) ? 16'h0400 : 16'h0400 + 16'(n), n, n % 3, n % 4, fin, 16'(n * 97));
    end
    // R2 R3 address wrap near top of address space
    run(1'b0, 16'hFFF0, 32, 0, 0, 16'h0080, 16'h1234);
    // R7 size rejects
    run(1'b0, 16'h0100, 0, 0, 0, 16'h0080, 16'h0);
    run(1'b0, 16'h0103, 33, 0, 0, 16'h0080, 16'h0);
    run(1'b0, 16'h0100, 63, 0, 0, 16'h0080, 16'h0);
    // R10 poll limit boundaries in both phases
    run(1'b0, 16'h0200, 4, MP - 1, MP - 1, 16'h0080, 16'h0A0A);
    run(1'b0, 16'h0200, 4, MP, 0, 16'h0080, 16'h0B0B);
    run(1'b0, 16'h0200, 4, 0, MP, 16'h0080, 16'h0C0C);
    // R9 single-word mode, count ignored, all outcomes
    run(1'b1, 16'h0207, 0, 0, 2, 16'h0080, 16'h3333);
    run(1'b1, 16'h0300, 50, 0, 0, 16'h0090, 16'h4444);
    run(1'b1, 16'h0311, 5, 0, 1, 16'h0092, 16'h5555);
    run(1'b1, 16'h0311, 1, 0, MP, 16'h0080, 16'h6666);
    run(1'b1, 16'h0000, 1, 0, MP - 1, 16'h0082, 16'h7777);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule